// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Sequencer

This block answers a processor's interrupt acknowledge cycles. It watches the active-low acknowledge input and counts its pulses. During each pulse that carries data, it drives one byte onto an 8-bit data bus. The block supports two bus protocols, chosen by an input that is sampled when a sequence starts:

- **Three-pulse protocol.** The byte sequence is a call opcode, then a low address byte, then a high address byte.
- **Two-pulse protocol.** The first pulse carries no data. The second pulse carries a single vector byte.

The interrupt level is taken from eight request lines under fixed priority, with line 0 the highest. The level is spliced into the address bytes at a position set by the programmed routine spacing, which is either 4 or 8 bytes.

The acknowledge input is synchronised to the system clock, and each sequence is driven by its edges. On the first falling edge of a sequence, the block freezes the winning level, the protocol and the spacing. When the first pulse ends, it presents that level as a 3-bit cascade code with its own enable. When the last pulse ends, it raises a one-clock, one-hot strobe that tells the request logic which level was serviced, and then it returns to idle.

Top module: `ack_vector_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, `bus_oe`, `cas_oe`, `bus_dout` and `clr_stb` are all zero.
- R2: In the three-pulse protocol (`two_pulse`=0), `bus_oe` is 1 and `bus_dout` is 8'hCD while the first pulse is low.
- R3: In the three-pulse protocol with `step_four`=1, the second pulse drives `{addr_hi[2:0], level[2:0], 2'b00}`.
- R4: In the three-pulse protocol with `step_four`=0, the second pulse drives `{addr_hi[2:1], level[2:0], 3'b000}`.
- R5: In the three-pulse protocol, the third pulse drives `addr_hi[10:3]`.
- R6: In the two-pulse protocol (`two_pulse`=1):
  - `bus_oe` stays 0 through the whole first pulse.
  - The second pulse drives `{addr_hi[10:6], level[2:0]}`, whatever the value of `step_four`.
- R7: The level is the lowest-numbered asserted bit of `irq_req`. When no bit is asserted, the level is 7.
- R8: The level is sampled at the first falling edge of a sequence. Changes on `irq_req` after that edge have no effect on any byte or strobe of that sequence.
- R9: `bus_oe` is 0 whenever the acknowledge input has been high for a few clocks, including between the pulses of a sequence.
- R10: `clr_stb` is one-hot on bit `level`. It is high for exactly one clock, after the rising edge of the last pulse of a sequence. At all other times it is zero.
- R11: `cas_oe` is 1, with `cas_code` equal to the level, from the end of the first pulse until the end of the last pulse. It is 0 during the first pulse.
- R12: `two_pulse` and `step_four` are sampled at the first falling edge of a sequence. Changing them later in the sequence has no effect on that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| inta_n | input | 1 | Interrupt acknowledge, active low, asynchronous to `clk` |
| irq_req | input | 8 | Pending interrupt requests; bit 0 has the highest priority |
| addr_hi | input | 11 | Programmed routine address bits 15..5 (bit 0 here is address bit 5) |
| step_four | input | 1 | Routine spacing: 1 selects 4 bytes, 0 selects 8 bytes |
| two_pulse | input | 1 | 1 selects the two-pulse protocol, 0 selects the three-pulse protocol |
| bus_dout | output | 8 | Vector byte; zero when not driven |
| bus_oe | output | 1 | Data bus drive enable; low means the bus is tri-stated |
| cas_code | output | 3 | Serviced level code for cascaded units |
| cas_oe | output | 1 | Cascade code valid |
| clr_stb | output | 8 | One-hot strobe that clears the serviced request |

## Verification
The assertions rely on the following assumptions about the inputs:
- Every acknowledge low and high phase lasts at least three clocks, so that each edge survives the synchroniser.
- No extra pulses arrive within a sequence.
- The requests, protocol and spacing inputs are steady around the first falling edge.

The stimulus respects these assumptions. It holds every low and high phase for five clocks, and it changes the requests, the protocol or the spacing only while the acknowledge input is high. Random requests, addresses and settings are mixed with directed cases: no request pending, requests changed mid-sequence, and protocol or spacing flipped after the first pulse.

// File: rtl/ack_vector_pkg.sv
package ack_vector_pkg;
  localparam int BYTE_W  = 8;
  localparam int NUM_IRQ = 8;
  localparam int LVL_W   = $clog2(NUM_IRQ);
  localparam int ADDR_W  = 11;
  localparam logic [BYTE_W-1:0] CALL_OP = 8'hCD;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ONE   = 2'd1,
    PH_TWO   = 2'd2,
    PH_THREE = 2'd3
  } phase_t;
endpackage

// File: rtl/inta_sync.sv
module inta_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic inta_n,
  output logic fall,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;
  logic              synced;

  assign synced = chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], inta_n};
      prev  <= synced;
    end
  end

  assign fall = prev & ~synced;
  assign rise = ~prev & synced;
endmodule

// File: rtl/level_pick.sv
module level_pick
  import ack_vector_pkg::*;
(
  input  logic [NUM_IRQ-1:0] req,
  output logic [LVL_W-1:0]   lvl
);
  logic [NUM_IRQ-1:0] below;

  always_comb begin
    lvl = LVL_W'(NUM_IRQ - 1);
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (req[i]) lvl = LVL_W'(i);
    end
  end

  assign below = (NUM_IRQ'(1) << lvl) - NUM_IRQ'(1);

  always_comb begin
    // R7
    pick_top_chk: assert ((req == '0) ? (lvl == LVL_W'(NUM_IRQ - 1))
                                      : (req[lvl] && ((req & below) == '0)));
  end
endmodule

// File: rtl/vector_mux.sv
module vector_mux
  import ack_vector_pkg::*;
(
  input  logic              two_mode,
  input  logic              step4,
  input  phase_t            phase,
  input  logic [LVL_W-1:0]  lvl,
  input  logic [ADDR_W-1:0] addr,
  output logic [BYTE_W-1:0] vbyte,
  output logic              drive
);
  always_comb begin
    vbyte = '0;
    drive = 1'b0;
    if (two_mode) begin
      if (phase == PH_TWO) begin
        vbyte = {addr[10:6], lvl};
        drive = 1'b1;
      end
    end else begin
      unique case (phase)
        PH_ONE: begin
          vbyte = CALL_OP;
          drive = 1'b1;
        end
        PH_TWO: begin
          vbyte = step4 ? {addr[2:0], lvl, 2'b00} : {addr[2:1], lvl, 3'b000};
          drive = 1'b1;
        end
        PH_THREE: begin
          vbyte = addr[10:3];
          drive = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ack_vector_seq.sv
module ack_vector_seq
  import ack_vector_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inta_n,
  input  logic [7:0]        irq_req,
  input  logic [10:0]       addr_hi,
  input  logic              step_four,
  input  logic              two_pulse,
  output logic [7:0]        bus_dout,
  output logic              bus_oe,
  output logic [2:0]        cas_code,
  output logic              cas_oe,
  output logic [7:0]        clr_stb
);
  logic fall, rise;
  logic [LVL_W-1:0] pick;

  phase_t             phase, ph_n;
  logic               in_pulse, ip_n;
  logic [LVL_W-1:0]   lvl_q, lvl_n;
  logic               mode_q, mode_n;
  logic               step_q, step_n;
  logic               cas_n;
  logic [NUM_IRQ-1:0] stb_n;
  logic [BYTE_W-1:0]  vbyte;
  logic               vdrive;
  phase_t             last_ph;

  inta_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .inta_n(inta_n), .fall(fall), .rise(rise)
  );

  level_pick u_pick (.req(irq_req), .lvl(pick));

  assign last_ph = mode_q ? PH_TWO : PH_THREE;

  always_comb begin
    ph_n   = phase;
    ip_n   = in_pulse;
    lvl_n  = lvl_q;
    mode_n = mode_q;
    step_n = step_q;
    cas_n  = cas_oe;
    stb_n  = '0;
    if (fall) begin
      ip_n = 1'b1;
      if (phase == PH_IDLE) begin
        lvl_n  = pick;
        mode_n = two_pulse;
        step_n = step_four;
        ph_n   = PH_ONE;
      end else if (phase != PH_THREE) begin
        ph_n = phase_t'(phase + 2'd1);
      end
    end else if (rise && in_pulse) begin
      ip_n = 1'b0;
      if (phase == PH_ONE) cas_n = 1'b1;
      if (phase == last_ph) begin
        ph_n  = PH_IDLE;
        cas_n = 1'b0;
        stb_n = NUM_IRQ'(1) << lvl_q;
      end
    end
  end

  vector_mux u_mux (
    .two_mode(mode_n), .step4(step_n), .phase(ph_n), .lvl(lvl_n),
    .addr(addr_hi), .vbyte(vbyte), .drive(vdrive)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      in_pulse <= 1'b0;
      lvl_q    <= '0;
      mode_q   <= 1'b0;
      step_q   <= 1'b0;
      cas_oe   <= 1'b0;
      cas_code <= '0;
      clr_stb  <= '0;
      bus_oe   <= 1'b0;
      bus_dout <= '0;
    end else begin
      phase    <= ph_n;
      in_pulse <= ip_n;
      lvl_q    <= lvl_n;
      mode_q   <= mode_n;
      step_q   <= step_n;
      cas_oe   <= cas_n;
      cas_code <= cas_n ? lvl_n : '0;
      clr_stb  <= stb_n;
      bus_oe   <= ip_n & vdrive;
      bus_dout <= (ip_n & vdrive) ? vbyte : '0;
    end
  end

  // R9
  oe_in_seq_chk: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> (phase != PH_IDLE && in_pulse));

  // R10
  clr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr_stb));

  // R10
  clr_single_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_stb != '0) |=> (clr_stb == '0));

  // R10
  clr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_stb != '0) |-> (phase == PH_IDLE && !cas_oe));

  // R8
  lvl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(lvl_q));

  // R6
  two_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q && phase == PH_ONE) |-> !bus_oe);

  // R11
  cas_in_seq_chk: assert property (@(posedge clk) disable iff (rst)
    cas_oe |-> (phase != PH_IDLE && phase != PH_ONE || !in_pulse));
endmodule

// File: tb/ack_vector_seq_test.sv
module ack_vector_seq_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inta_n = 1'b1;
  logic [7:0]  irq_req = '0;
  logic [10:0] addr_hi = '0;
  logic        step_four = 1'b0;
  logic        two_pulse = 1'b0;
  logic [7:0]  bus_dout;
  logic        bus_oe;
  logic [2:0]  cas_code;
  logic        cas_oe;
  logic [7:0]  clr_stb;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ack_vector_seq uut (
    .clk(clk), .rst(rst), .inta_n(inta_n), .irq_req(irq_req),
    .addr_hi(addr_hi), .step_four(step_four), .two_pulse(two_pulse),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .cas_code(cas_code),
    .cas_oe(cas_oe), .clr_stb(clr_stb)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_lvl(input logic [7:0] r);
    for (int i = 0; i < 8; i++) if (r[i]) return 3'(i);
    return 3'd7;
  endfunction

  function automatic logic [7:0] exp_byte(input bit two, input bit s4, input int p,
                                          input logic [2:0] l, input logic [10:0] a);
    if (two) return (p == 2) ? {a[10:6], l} : 8'h00;
    if (p == 1) return 8'hCD;
    if (p == 2) return s4 ? {a[2:0], l, 2'b00} : {a[2:1], l, 3'b000};
    return a[10:3];
  endfunction

  // one pulse: low 5 clocks, high 5 clocks; samples late in each phase
  task automatic do_pulse(output logic oe_in, output logic [7:0] d_in,
                          output logic cv, output logic [2:0] cc,
                          output logic oe_hi, output int sn, output logic [7:0] sv);
    @(negedge clk) inta_n = 1'b0;
    sn = 0; sv = '0;
    repeat (5) begin
      @(negedge clk);
      if (clr_stb != '0) begin sn++; sv = clr_stb; end
    end
    oe_in = bus_oe; d_in = bus_dout; cv = cas_oe; cc = cas_code;
    inta_n = 1'b1;
    repeat (5) begin
      @(negedge clk);
      if (clr_stb != '0) begin sn++; sv = clr_stb; end
    end
    oe_hi = bus_oe;
  endtask

  task automatic run_seq(input bit two, input bit s4, input logic [7:0] r0,
                         input logic [7:0] r1, input logic [10:0] a, input bit flip);
    logic oe_in, oe_hi, cv;
    logic [7:0] d_in, sv;
    logic [2:0] cc, l;
    int sn, np;
    two_pulse = two; step_four = s4; irq_req = r0; addr_hi = a;
    l = exp_lvl(r0);
    np = two ? 2 : 3;
    for (int p = 1; p <= np; p++) begin
      do_pulse(oe_in, d_in, cv, cc, oe_hi, sn, sv);
      if (p == 1) begin
        irq_req = r1; // R8
        if (flip) begin two_pulse = ~two; step_four = ~s4; end // R12
      end
      chk(oe_in == !(two && p == 1), two ? "R6 oe" : "R2 oe", oe_in, !(two && p == 1));
      if (oe_in)
        chk(d_in == exp_byte(two, s4, p, l, a),
            two ? "R6 byte" : (p == 1 ? "R2 byte" : (p == 3 ? "R5 byte" :
            (s4 ? "R3 byte" : "R4 byte"))), d_in, exp_byte(two, s4, p, l, a));
      chk(oe_hi == 1'b0, "R9 oe high", oe_hi, 0);
      chk(cv == (p > 1), "R11 cas_oe", cv, p > 1);
      if (p > 1) chk(cc == l, "R11 cas_code R7", cc, l);
      if (p == np) begin
        chk(sn == 1, "R10 strobe count", sn, 1);
        chk(sv == (8'h1 << l), "R10 strobe R7", sv, 8'h1 << l);
      end else begin
        chk(sn == 0, "R10 early strobe", sn, 0);
      end
    end
    @(negedge clk);
    chk(cas_oe == 1'b0, "R11 cas after", cas_oe, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk(bus_oe == 1'b0 && cas_oe == 1'b0, "R1 enables", {bus_oe, cas_oe}, 0);
    chk(bus_dout == 8'h00 && clr_stb == 8'h00, "R1 data", {bus_dout, clr_stb}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(bus_oe == 1'b0 && clr_stb == 8'h00, "R1 after", {bus_oe, clr_stb}, 0);
    repeat (4) @(negedge clk);

    run_seq(1'b0, 1'b1, 8'b0010_1000, 8'b0010_1000, 11'h5A5, 1'b0); // R3
    run_seq(1'b0, 1'b0, 8'b1000_0100, 8'b1000_0100, 11'h3C6, 1'b0); // R4
    run_seq(1'b1, 1'b1, 8'b0100_0000, 8'b0100_0000, 11'h7FF, 1'b0); // R6
    run_seq(1'b1, 1'b0, 8'b0000_0000, 8'b0000_0000, 11'h2A9, 1'b0); // R7
    run_seq(1'b0, 1'b1, 8'b0000_0000, 8'b1111_1111, 11'h1F1, 1'b0); // R7 R8
    run_seq(1'b0, 1'b0, 8'b1000_0000, 8'b0000_0001, 11'h6B3, 1'b1); // R8 R12
    run_seq(1'b1, 1'b0, 8'b0001_0000, 8'b0000_0010, 11'h4D2, 1'b1); // R12
    run_seq(1'b0, 1'b1, 8'b1111_1111, 8'b0000_0000, 11'h000, 1'b0); // R5

    for (int k = 0; k < 40; k++) begin
      run_seq(1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom),
              11'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule